// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

This block is a hardware engine that renews every byte of a small nonvolatile storage array by reading each location and writing the same value back. It acts as a bus master on the register interface of the array's controller. It uses four registers there: an address register, a data register, a control/status register and an unlock key register. Software or a supervisor pulses `start` once, and the engine then walks the whole array without further help.

For each location the engine loads the controller's data register by requesting a read. It then gives the two-key unlock, sets the write-start bit, and polls the status until the controller reports that the write has finished. It then moves to the next address. The walk ends when the address counter rolls over to zero. Write enable is then dropped and `done` pulses for one cycle. The engine never touches the data register itself, so the value written back is always the value just read.

Bus encoding: `bus_sel` 0 selects the address register, 1 the data register, 2 the control/status register and 3 the key register. In the control word, bit 0 requests a read, bit 1 starts a write, and bit 2 is write enable. All other bits are zero.

Top module: `nvm_refresh_seq`

## Requirements
- R1: While `rst` is high and afterwards until a start, `busy` and `done` are 0 and neither `bus_wr` nor `bus_rd` is asserted.
- R2: In the cycle after `start` is seen while idle, the engine writes 0 to the address register (`bus_sel`=0). In the next cycle it writes 8'h04 (write enable only) to the control register (`bus_sel`=2).
- R3: For each location, four bus writes follow in consecutive cycles: control 8'h05 (enable plus read request), key (`bus_sel`=3) 8'h55, key 8'hAA, then control 8'h06 (enable plus write start).
- R4: After the write start, the engine reads the control register (`bus_rd`, `bus_sel`=2) and samples `bus_rdata` one cycle later. It repeats this for as long as bit 1 of the returned status is 1. It does not move to another address or request another read while that bit is 1.
- R5: Once the status shows the write complete, the address advances by exactly one and is written to the address register. Every location from 0 to DEPTH-1 is written exactly once per run, in ascending order.
- R6: When the increment wraps the address to zero, no further location is processed. Instead the engine writes 8'h00 to the control register, clearing write enable.
- R7: `done` is high for exactly one cycle: the cycle right after the write that clears write enable. `busy` is 0 from the following cycle on.
- R8: A `start` pulse that arrives while `busy` is 1 has no effect. The run proceeds, and each location is still written once with a single `done` pulse.
- R9: DEPTH is 128 or 256. Every value written to the address register is below DEPTH, so the top address bit stays 0 for 128.
- R10: The engine never writes the data register, so the array contents after a run equal those before it.
- R11: `bus_wr` and `bus_rd` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a refresh walk |
| busy | output | 1 | High from the cycle after start until the cycle with the done pulse |
| done | output | 1 | One-cycle pulse at the end of a walk |
| bus_wr | output | 1 | Register write strobe to the array controller |
| bus_rd | output | 1 | Register read strobe to the array controller |
| bus_sel | output | 2 | Register select: 0 address, 1 data, 2 control/status, 3 key |
| bus_wdata | output | 8 | Write data for the selected register |
| bus_rdata | input | 8 | Registered read data, valid the cycle after `bus_rd` |

## Verification
The assertions assume that the controller answers a status read with registered data one cycle later, that the reserved status bits are zero, and that the write-busy bit eventually clears. The bench's controller model keeps to these rules: it returns the status in the cycle after the read strobe and holds the busy bit for a fixed latency. It checks every access against the unlock order, the read-before-write rule and the ascending address order. Two instances run side by side, one with 128 entries and a short write latency and one with 256 entries and a long write latency. The 256-entry instance therefore polls several times per location, and the wrap is exercised at both sizes.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    localparam int CB_RD  = 0;
    localparam int CB_WR  = 1;
    localparam int CB_WEN = 2;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ZERO,
        ST_ARM,
        ST_READ,
        ST_KEY1,
        ST_KEY2,
        ST_FIRE,
        ST_POLL,
        ST_CHECK,
        ST_STEP,
        ST_DONE
    } step_e;

    typedef struct packed {
        logic       wr;
        logic       rd;
        reg_sel_e   sel;
        logic [7:0] wdata;
    } bus_cmd_t;

    function automatic logic [7:0] ctrl_word(input logic wen, input logic wr, input logic rd);
        logic [7:0] w;
        w = 8'h00;
        w[CB_WEN] = wen;
        w[CB_WR]  = wr;
        w[CB_RD]  = rd;
        return w;
    endfunction

endpackage

// File: rtl/nrs_addr_walker.sv
module nrs_addr_walker #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              at_zero
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr <= '0;
        end else if (advance) begin
            addr <= addr + ADDR_W'(1);
        end
    end

    assign at_zero = (addr == '0);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr) |-> (addr == ADDR_W'($past(addr) + ADDR_W'(1))) || (addr == '0));

endmodule

// File: rtl/nrs_step_fsm.sv
module nrs_step_fsm
    import nrs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  wr_pending,
    input  logic  at_zero,
    output step_e state,
    output logic  clear,
    output logic  advance,
    output logic  busy,
    output logic  done
);

    step_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_ZERO;
            ST_ZERO:  nxt = ST_ARM;
            ST_ARM:   nxt = ST_READ;
            ST_READ:  nxt = ST_KEY1;
            ST_KEY1:  nxt = ST_KEY2;
            ST_KEY2:  nxt = ST_FIRE;
            ST_FIRE:  nxt = ST_POLL;
            ST_POLL:  nxt = ST_CHECK;
            ST_CHECK: nxt = wr_pending ? ST_POLL : ST_STEP;
            ST_STEP:  nxt = at_zero ? ST_DONE : ST_READ;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign clear   = (state == ST_IDLE) && start;
    assign advance = (state == ST_CHECK) && !wr_pending;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (state != ST_ZERO));

    // R4
    poll_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && wr_pending) |=> (state == ST_POLL));

endmodule

// File: rtl/nrs_bus_cmd.sv
module nrs_bus_cmd
    import nrs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  step_e             state,
    input  logic [ADDR_W-1:0] addr,
    input  logic              at_zero,
    output bus_cmd_t          cmd
);

    always_comb begin
        cmd = '{wr: 1'b0, rd: 1'b0, sel: SEL_ADDR, wdata: 8'h00};
        unique case (state)
            ST_ZERO:  cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_ADDR, wdata: 8'h00};
            ST_ARM:   cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_CTRL, wdata: ctrl_word(1'b1, 1'b0, 1'b0)};
            ST_READ:  cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_CTRL, wdata: ctrl_word(1'b1, 1'b0, 1'b1)};
            ST_KEY1:  cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_KEY,  wdata: KEY_FIRST};
            ST_KEY2:  cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_KEY,  wdata: KEY_SECOND};
            ST_FIRE:  cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_CTRL, wdata: ctrl_word(1'b1, 1'b1, 1'b0)};
            ST_POLL:  cmd = '{wr: 1'b0, rd: 1'b1, sel: SEL_CTRL, wdata: 8'h00};
            ST_STEP: begin
                if (at_zero) cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_CTRL, wdata: ctrl_word(1'b0, 1'b0, 1'b0)};
                else         cmd = '{wr: 1'b1, rd: 1'b0, sel: SEL_ADDR, wdata: 8'(addr)};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nvm_refresh_seq.sv
module nvm_refresh_seq
    import nrs_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       busy,
    output logic       done,
    output logic       bus_wr,
    output logic       bus_rd,
    output logic [1:0] bus_sel,
    output logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata
);

    localparam int ADDR_W = (DEPTH > 128) ? 8 : 7;

    step_e             state;
    logic              clear, advance, at_zero, wr_pending;
    logic [ADDR_W-1:0] addr;
    bus_cmd_t          cmd;

    assign wr_pending = bus_rdata[CB_WR];

    nrs_addr_walker #(.ADDR_W(ADDR_W)) i_walker (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .advance (advance),
        .addr    (addr),
        .at_zero (at_zero)
    );

    nrs_step_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .wr_pending (wr_pending),
        .at_zero    (at_zero),
        .state      (state),
        .clear      (clear),
        .advance    (advance),
        .busy       (busy),
        .done       (done)
    );

    nrs_bus_cmd #(.ADDR_W(ADDR_W)) i_cmd (
        .state   (state),
        .addr    (addr),
        .at_zero (at_zero),
        .cmd     (cmd)
    );

    assign bus_wr    = cmd.wr;
    assign bus_rd    = cmd.rd;
    assign bus_sel   = cmd.sel;
    assign bus_wdata = cmd.wdata;

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    // R3
    key_then_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == SEL_KEY && bus_wdata == KEY_SECOND)
        |=> (bus_wr && bus_sel == SEL_CTRL && bus_wdata == 8'h06));

    // R9
    addr_range_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == SEL_ADDR) |-> (int'(bus_wdata) < DEPTH));

    // R10
    no_data_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_sel == SEL_DATA));

    // R7
    done_after_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_wr && bus_sel == SEL_CTRL && bus_wdata == 8'h00));

    // R4
    poll_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK && wr_pending) |=> $stable(addr));

    // R4
    status_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |-> (bus_rdata[7:3] == 5'b0 && !bus_rdata[CB_RD] && bus_rdata[CB_WEN]));

endmodule

// File: tb/test_nvm_refresh_seq.sv
module test_nrs_mem #(
    parameter int DEPTH = 128,
    parameter int LAT   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wen_o,
    output int         errs,
    output int         wr_total,
    output int         rd_total
);
    logic [7:0] mem [DEPTH];
    int         wcnt [DEPTH];
    logic [7:0] addr_r, data_r, rd_addr;
    logic       rd_valid, wr_busy;
    int         busy_cnt;
    logic [1:0] key_st;

    always @(posedge clk) begin
        int e;
        e = 0;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i]  <= 8'((i * 37 + 5) & 255);
                wcnt[i] <= 0;
            end
            addr_r <= 0; data_r <= 0; rd_addr <= 0; rd_valid <= 0; wr_busy <= 0;
            busy_cnt <= 0; key_st <= 0; wen_o <= 0; bus_rdata <= 0;
            errs <= 0; wr_total <= 0; rd_total <= 0;
        end else begin
            if (wr_busy) begin
                if (busy_cnt == 0) begin
                    wr_busy <= 0;
                    mem[addr_r] <= data_r;
                    wcnt[addr_r] <= wcnt[addr_r] + 1;
                    if (int'(addr_r) != wr_total % DEPTH) e++;
                    wr_total <= wr_total + 1;
                end else begin
                    busy_cnt <= busy_cnt - 1;
                end
            end
            if (bus_rd) begin
                if (bus_sel != 2'd2) e++;
                bus_rdata <= {5'b0, wen_o, wr_busy, 1'b0};
                rd_total <= rd_total + 1;
            end
            if (bus_wr) begin
                if (bus_sel != 2'd3) key_st <= 0;
                case (bus_sel)
                    2'd0: begin
                        if (wr_busy) e++;
                        if (int'(bus_wdata) >= DEPTH) e++;
                        addr_r <= bus_wdata;
                        rd_valid <= 0;
                    end
                    2'd1: e++;
                    2'd2: begin
                        wen_o <= bus_wdata[2];
                        if (bus_wdata[0] && bus_wdata[1]) e++;
                        if (bus_wdata[0]) begin
                            if (wr_busy) e++;
                            data_r <= mem[addr_r];
                            rd_addr <= addr_r;
                            rd_valid <= 1;
                        end
                        if (bus_wdata[1]) begin
                            if (bus_wdata[2] && key_st == 2 && rd_valid && rd_addr == addr_r && !wr_busy) begin
                                wr_busy <= 1;
                                busy_cnt <= LAT;
                            end else begin
                                e++;
                            end
                        end
                    end
                    default: begin
                        if (bus_wdata == 8'h55) key_st <= 1;
                        else if (bus_wdata == 8'hAA && key_st == 1) key_st <= 2;
                        else begin key_st <= 0; e++; end
                    end
                endcase
            end
            errs <= errs + e;
        end
    end
endmodule

module test_nvm_refresh_seq;
    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    always #2 clk = ~clk;

    logic       busy_a, done_a, wr_a, rd_a, wen_a;
    logic [1:0] sel_a;
    logic [7:0] wd_a, rdat_a;
    int         errs_a, wrt_a, rdt_a;
    logic       busy_b, done_b, wr_b, rd_b, wen_b;
    logic [1:0] sel_b;
    logic [7:0] wd_b, rdat_b;
    int         errs_b, wrt_b, rdt_b;

    nvm_refresh_seq #(.DEPTH(128)) i_nvm_refresh_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy_a), .done(done_a),
        .bus_wr(wr_a), .bus_rd(rd_a), .bus_sel(sel_a), .bus_wdata(wd_a), .bus_rdata(rdat_a));
    test_nrs_mem #(.DEPTH(128), .LAT(3)) i_mem_a (
        .clk(clk), .rst(rst), .bus_wr(wr_a), .bus_rd(rd_a), .bus_sel(sel_a), .bus_wdata(wd_a),
        .bus_rdata(rdat_a), .wen_o(wen_a), .errs(errs_a), .wr_total(wrt_a), .rd_total(rdt_a));

    nvm_refresh_seq #(.DEPTH(256)) i_nvm_refresh_seq_w (
        .clk(clk), .rst(rst), .start(start), .busy(busy_b), .done(done_b),
        .bus_wr(wr_b), .bus_rd(rd_b), .bus_sel(sel_b), .bus_wdata(wd_b), .bus_rdata(rdat_b));
    test_nrs_mem #(.DEPTH(256), .LAT(9)) i_mem_b (
        .clk(clk), .rst(rst), .bus_wr(wr_b), .bus_rd(rd_b), .bus_sel(sel_b), .bus_wdata(wd_b),
        .bus_rdata(rdat_b), .wen_o(wen_b), .errs(errs_b), .wr_total(wrt_b), .rd_total(rdt_b));

    int checks = 0, fails = 0, cyc = 0;
    int done_hi_a = 0, done_hi_b = 0, both_a = 0, both_b = 0;
    int disarm_cyc_a = -1, done_cyc_a = -1, disarm_cyc_b = -1, done_cyc_b = -1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (done_a) begin done_hi_a <= done_hi_a + 1; done_cyc_a <= cyc; end
            if (done_b) begin done_hi_b <= done_hi_b + 1; done_cyc_b <= cyc; end
            if (wr_a && sel_a == 2'd2 && wd_a == 8'h00) disarm_cyc_a <= cyc;
            if (wr_b && sel_b == 2'd2 && wd_b == 8'h00) disarm_cyc_b <= cyc;
            if (wr_a && rd_a) both_a <= both_a + 1;
            if (wr_b && rd_b) both_b <= both_b + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_is(input string req, input logic w, input logic [1:0] s, input logic [7:0] d);
        chk(wr_a == w && sel_a == s && wd_a == d, req, {wr_a, sel_a, wd_a}, {w, s, d});
        chk(wr_b == w && sel_b == s && wd_b == d, req, {wr_b, sel_b, wd_b}, {w, s, d});
    endtask

    task automatic wait_idle(output bit ok);
        int n;
        n = 0;
        ok = 1;
        @(negedge clk);
        while ((busy_a || busy_b) && n < 60000) begin
            @(negedge clk);
            n++;
        end
        if (busy_a || busy_b) ok = 0;
    endtask

    task automatic final_checks(input int pass);
        int bad_a, bad_b, mem_a, mem_b;
        bad_a = 0; bad_b = 0; mem_a = 0; mem_b = 0;
        for (int i = 0; i < 128; i++) begin
            if (i_mem_a.wcnt[i] != pass) bad_a++;
            if (i_mem_a.mem[i] != 8'((i * 37 + 5) & 255)) mem_a++;
        end
        for (int i = 0; i < 256; i++) begin
            if (i_mem_b.wcnt[i] != pass) bad_b++;
            if (i_mem_b.mem[i] != 8'((i * 37 + 5) & 255)) mem_b++;
        end
        // R5 / R9: every location written once per run, in order, within range
        chk(bad_a == 0, "R5", bad_a, 0);
        chk(bad_b == 0, "R5", bad_b, 0);
        chk(wrt_a == 128 * pass, "R9", wrt_a, 128 * pass);
        chk(wrt_b == 256 * pass, "R9", wrt_b, 256 * pass);
        // R3 / R4: controller model saw no ordering or polling violation
        chk(errs_a == 0, "R3", errs_a, 0);
        chk(errs_b == 0, "R4", errs_b, 0);
        // R10: contents preserved
        chk(mem_a == 0, "R10", mem_a, 0);
        chk(mem_b == 0, "R10", mem_b, 0);
        // R6: write enable cleared at the end
        chk(wen_a == 0, "R6", wen_a, 0);
        chk(wen_b == 0, "R6", wen_b, 0);
        // R7: one done pulse per run, right after the disarm write
        chk(done_hi_a == pass, "R7", done_hi_a, pass);
        chk(done_hi_b == pass, "R7", done_hi_b, pass);
        chk(done_cyc_a == disarm_cyc_a + 1, "R7", done_cyc_a, disarm_cyc_a + 1);
        chk(done_cyc_b == disarm_cyc_b + 1, "R7", done_cyc_b, disarm_cyc_b + 1);
        chk(!busy_a && !done_a && !busy_b && !done_b, "R7", {busy_a, done_a, busy_b, done_b}, 0);
        // R11
        chk(both_a == 0 && both_b == 0, "R11", both_a + both_b, 0);
    endtask

    initial begin
        bit ok;
        repeat (3) @(negedge clk);
        // R1: during reset
        chk(!busy_a && !done_a && !wr_a && !rd_a, "R1", {busy_a, done_a, wr_a, rd_a}, 0);
        chk(!busy_b && !done_b && !wr_b && !rd_b, "R1", {busy_b, done_b, wr_b, rd_b}, 0);
        rst = 0;
        repeat (4) @(negedge clk);
        // R1: idle after reset
        chk(!busy_a && !wr_a && !rd_a && !busy_b && !wr_b && !rd_b, "R1", {busy_a, wr_a, rd_a}, 0);

        // first run: R2 and R3 step sequence
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy_a && busy_b, "R2", {busy_a, busy_b}, 3);
        bus_is("R2", 1'b1, 2'd0, 8'h00);
        @(negedge clk); bus_is("R2", 1'b1, 2'd2, 8'h04);
        @(negedge clk); bus_is("R3", 1'b1, 2'd2, 8'h05);
        @(negedge clk); bus_is("R3", 1'b1, 2'd3, 8'h55);
        @(negedge clk); bus_is("R3", 1'b1, 2'd3, 8'hAA);
        @(negedge clk); bus_is("R3", 1'b1, 2'd2, 8'h06);
        @(negedge clk);
        // R4: status poll follows the write start
        chk(rd_a && sel_a == 2'd2 && !wr_a, "R4", {rd_a, sel_a}, 3'b110);

        // R8: start pulses while busy are ignored
        repeat (300) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (700) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy_a || busy_b, "R8", busy_a, 1);

        wait_idle(ok);
        chk(ok, "R7", ok, 1);
        final_checks(1);
        // R4: long write latency forces several polls per location
        chk(rdt_b >= 2 * 256, "R4", rdt_b, 2 * 256);
        // R8: stray starts added no extra writes after the run
        repeat (20) @(negedge clk);
        chk(wrt_a == 128 && wrt_b == 256 && !busy_a && !busy_b, "R8", wrt_a + wrt_b, 384);

        // second run from idle
        start = 1;
        @(negedge clk);
        start = 0;
        bus_is("R2", 1'b1, 2'd0, 8'h00);
        wait_idle(ok);
        chk(ok, "R7", ok, 1);
        final_checks(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule